// File: doc/BRIEF.md
# Lane Alignment Sequence Tracker

This block watches one receive lane of a multi-gigabit converter link after symbol decoding. Each clock it takes one octet and a flag that tells whether the octet is a control character. While the link idles, the lane carries a steady stream of comma characters. The block waits for the multiframe start character (0x1C, control) and then follows four multiframes of `MF_FRAMES × FRAME_OCTETS` octets each. It checks that control characters appear only where the sequence allows them.

The second multiframe carries a ten-octet link configuration record. The record is opened by the control character 0x9C. The block captures the record, decodes the lane identifier and the scrambling flag, and compares the lane count, octets per frame, frames per multiframe and converter count against its own parameters. A clean end of the fourth multiframe raises a sticky done flag. Any placement fault raises a one-cycle error pulse and sends the tracker back to the comma search.

Top module: `lane_ilas_checker`

## Requirements
- R1: A synchronous active-high `rst` returns the tracker to comma search. In the cycle after a reset edge, `ilas_done`, `ilas_error`, `cfg_valid` and `cfg_mismatch` are all low.
- R2: While searching, every octet other than 0x1C with the control flag set is ignored. This includes commas (0xBC control), 0x7C or 0x9C control characters, and 0x1C sent as data. None of these raises `ilas_error`.
- R3: A 0x1C control octet seen while searching is position 0 of the first multiframe. Each multiframe spans `MF_FRAMES*FRAME_OCTETS` octets (18 by default), at positions 0 to 17.
- R4: A 0x7C control octet at the last position of the fourth multiframe sets `ilas_done` one cycle later. `ilas_done` then stays high until reset, and all later octets are ignored: no error is raised and the captured record is not changed.
- R5: The last position of every multiframe must hold 0x7C control. A control octet at any other data position, including an early 0x7C, is a violation. Any violation pulses `ilas_error` high for exactly one cycle and returns the tracker to search.
- R6: Position 0 of multiframes two to four must hold 0x1C control. Anything else there is a violation.
- R7: Position 1 of the second multiframe must hold 0x9C control. Every other position that is not a start or end position must carry the control flag clear. A violation of either rule raises the error pulse.
- R8: Positions 2 to 11 of the second multiframe are configuration octets 0 to 9. Octet i appears on `cfg_octets[8i+7:8i]`. `cfg_valid` rises in the cycle after octet 9 is taken.
- R9: `cfg_lane_id` is octet 2 bits [4:0]. `cfg_scramble` is octet 3 bit 7.
- R10: `cfg_mismatch` is high when `cfg_valid` is high and any of these fields differs from the parameters: octet 3 [4:0] against LANE_COUNT−1, octet 4 against FRAME_OCTETS−1, octet 5 [4:0] against MF_FRAMES−1, or octet 6 against CONV_COUNT−1.
- R11: The captured record and `cfg_valid` survive an error. `cfg_valid` clears in the cycle after the next start character is accepted from search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_octet | input | 8 | Decoded octet of this lane |
| rx_is_ctrl | input | 1 | Octet is a control character |
| ilas_done | output | 1 | Sequence completed, sticky until reset |
| ilas_error | output | 1 | One-cycle pulse on a placement violation |
| cfg_valid | output | 1 | All ten configuration octets captured |
| cfg_mismatch | output | 1 | Captured L, F, K or M differs from parameters |
| cfg_octets | output | 80 | Captured configuration octets, octet i at bits [8i+7:8i] |
| cfg_lane_id | output | 5 | Lane identifier from the record |
| cfg_scramble | output | 1 | Scrambling flag from the record |

## Verification
The bound properties check several rules on every cycle. Each detected placement violation must be followed by an error pulse one cycle wide. Done must never drop without reset, and it must only rise after a 0x7C control octet. A mismatch must never appear without a valid record, and accepting a start character must clear `cfg_valid`. Other behaviour only the bench scenarios can show. These are the exact position at which a misplaced start, end, delimiter or data control character is caught; the cycle at which the record becomes valid; and the decoded field values. The same goes for the record surviving an error, and for octets being ignored while searching and after completion.

// File: rtl/ilas_pkg.sv
package ilas_pkg;

  localparam logic [7:0] CH_COMMA    = 8'hBC;
  localparam logic [7:0] CH_MF_START = 8'h1C;
  localparam logic [7:0] CH_MF_END   = 8'h7C;
  localparam logic [7:0] CH_CFG_OPEN = 8'h9C;

  // configuration record layout
  localparam int CFG_OCTETS    = 10;
  localparam int CFG_MF        = 1;   // zero-based multiframe holding the record
  localparam int CFG_FIRST_POS = 2;   // position of octet 0 inside that multiframe
  localparam int IDX_LANE_ID   = 2;
  localparam int IDX_LANES     = 3;
  localparam int IDX_FOCT      = 4;
  localparam int IDX_KFR       = 5;
  localparam int IDX_CONV      = 6;

  typedef enum logic [1:0] {ST_SEARCH, ST_RUN, ST_DONE} trk_state_e;
  typedef enum logic [1:0] {SLOT_START, SLOT_END, SLOT_OPEN, SLOT_DATA} slot_e;

  function automatic int mf_octets(int frames, int octets);
    return frames * octets;
  endfunction

  function automatic logic cfg_differs(logic [7:0] oct_l, logic [7:0] oct_f,
                                       logic [7:0] oct_k, logic [7:0] oct_m,
                                       int lanes, int foct, int kfr, int conv);
    return (oct_l[4:0] != 5'(lanes - 1)) || (oct_f != 8'(foct - 1)) ||
           (oct_k[4:0] != 5'(kfr - 1))   || (oct_m != 8'(conv - 1));
  endfunction

endpackage

// File: rtl/ilas_slot_pos.sv
// Position inside the current multiframe and multiframe index.
module ilas_slot_pos #(
  parameter int MF_LEN = 18,
  parameter int MF_NUM = 4,
  parameter int POS_W  = 5,
  parameter int MFI_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_first,
  input  logic             advance,
  output logic [POS_W-1:0] pos,
  output logic [MFI_W-1:0] mf_idx,
  output logic             at_last_mf
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(MF_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      mf_idx <= '0;
    end else if (load_first) begin
      pos    <= POS_W'(1);         // start octet already consumed
      mf_idx <= '0;
    end else if (advance) begin
      if (pos == LAST_POS) begin
        pos    <= '0;
        mf_idx <= mf_idx + MFI_W'(1);
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  assign at_last_mf = (mf_idx == MFI_W'(MF_NUM - 1));
endmodule

// File: rtl/ilas_slot_check.sv
// Classifies the current slot and judges the octet against it.
module ilas_slot_check
  import ilas_pkg::*;
#(
  parameter int MF_LEN = 18,
  parameter int POS_W  = 5,
  parameter int MFI_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic [POS_W-1:0] pos,
  input  logic [MFI_W-1:0] mf_idx,
  input  logic [7:0]       octet,
  input  logic             is_ctrl,
  output slot_e            kind,
  output logic             slot_ok,
  output logic             cfg_slot,
  output logic [IDX_W-1:0] cfg_idx
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(MF_LEN - 1);
  localparam logic [POS_W-1:0] CFG_LO   = POS_W'(CFG_FIRST_POS);
  localparam logic [POS_W-1:0] CFG_HI   = POS_W'(CFG_FIRST_POS + CFG_OCTETS);

  logic in_cfg_mf;
  assign in_cfg_mf = (mf_idx == MFI_W'(CFG_MF));

  always_comb begin
    if (pos == '0)                           kind = SLOT_START;
    else if (pos == LAST_POS)                kind = SLOT_END;
    else if (in_cfg_mf && pos == POS_W'(1))  kind = SLOT_OPEN;
    else                                     kind = SLOT_DATA;

    unique case (kind)
      SLOT_START: slot_ok = is_ctrl && (octet == CH_MF_START);
      SLOT_END:   slot_ok = is_ctrl && (octet == CH_MF_END);
      SLOT_OPEN:  slot_ok = is_ctrl && (octet == CH_CFG_OPEN);
      default:    slot_ok = !is_ctrl;
    endcase
  end

  assign cfg_slot = in_cfg_mf && (pos >= CFG_LO) && (pos < CFG_HI);
  assign cfg_idx  = IDX_W'(pos - CFG_LO);
endmodule

// File: rtl/ilas_cfg_store.sv
// Holds the configuration record and compares it with the build parameters.
module ilas_cfg_store
  import ilas_pkg::*;
#(
  parameter int FRAME_OCTETS = 6,
  parameter int MF_FRAMES    = 3,
  parameter int LANE_COUNT   = 2,
  parameter int CONV_COUNT   = 2,
  parameter int IDX_W        = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  output logic [8*CFG_OCTETS-1:0] cfg_flat,
  output logic                    valid,
  output logic                    mismatch,
  output logic [4:0]              lane_id,
  output logic                    scramble
);
  logic [7:0] cfg_q [CFG_OCTETS];
  logic       last_write;

  assign last_write = wr_en && (wr_idx == IDX_W'(CFG_OCTETS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_OCTETS; i++) cfg_q[i] <= '0;
      valid <= 1'b0;
    end else begin
      for (int i = 0; i < CFG_OCTETS; i++)
        if (wr_en && wr_idx == IDX_W'(i)) cfg_q[i] <= wr_data;
      if (clear)           valid <= 1'b0;
      else if (last_write) valid <= 1'b1;
    end
  end

  for (genvar g = 0; g < CFG_OCTETS; g++) begin : g_flat
    assign cfg_flat[8*g +: 8] = cfg_q[g];
  end

  assign mismatch = valid && cfg_differs(cfg_q[IDX_LANES], cfg_q[IDX_FOCT], cfg_q[IDX_KFR],
                                         cfg_q[IDX_CONV], LANE_COUNT, FRAME_OCTETS,
                                         MF_FRAMES, CONV_COUNT);
  assign lane_id  = cfg_q[IDX_LANE_ID][4:0];
  assign scramble = cfg_q[IDX_LANES][7];
endmodule

// File: rtl/lane_ilas_checker.sv
// Top: sequence state machine for one lane.
// Requires MF_FRAMES*FRAME_OCTETS >= CFG_FIRST_POS + CFG_OCTETS + 1.
module lane_ilas_checker
  import ilas_pkg::*;
#(
  parameter int FRAME_OCTETS = 6,
  parameter int MF_FRAMES    = 3,
  parameter int LANE_COUNT   = 2,
  parameter int CONV_COUNT   = 2,
  parameter int ILAS_MFS     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              rx_octet,
  input  logic                    rx_is_ctrl,
  output logic                    ilas_done,
  output logic                    ilas_error,
  output logic                    cfg_valid,
  output logic                    cfg_mismatch,
  output logic [8*CFG_OCTETS-1:0] cfg_octets,
  output logic [4:0]              cfg_lane_id,
  output logic                    cfg_scramble
);
  localparam int MF_LEN = mf_octets(MF_FRAMES, FRAME_OCTETS);
  localparam int POS_W  = $clog2(MF_LEN);
  localparam int MFI_W  = (ILAS_MFS > 1) ? $clog2(ILAS_MFS) : 1;
  localparam int IDX_W  = $clog2(CFG_OCTETS);

  trk_state_e       state;
  logic             done_q, err_q;
  logic [POS_W-1:0] pos;
  logic [MFI_W-1:0] mf_idx;
  logic             at_last_mf;
  slot_e            kind;
  logic             slot_ok, cfg_slot;
  logic [IDX_W-1:0] cfg_idx;

  // named events, also used by the bound checker
  logic running, start_seen, violation, slot_pass, seq_complete, cfg_write;
  assign running      = (state == ST_RUN);
  assign start_seen   = (state == ST_SEARCH) && rx_is_ctrl && (rx_octet == CH_MF_START);
  assign violation    = running && !slot_ok;
  assign slot_pass    = running && slot_ok;
  assign seq_complete = slot_pass && (kind == SLOT_END) && at_last_mf;
  assign cfg_write    = slot_pass && cfg_slot;

  ilas_slot_pos #(.MF_LEN(MF_LEN), .MF_NUM(ILAS_MFS), .POS_W(POS_W), .MFI_W(MFI_W)) u_pos (
    .clk(clk), .rst(rst), .load_first(start_seen), .advance(slot_pass),
    .pos(pos), .mf_idx(mf_idx), .at_last_mf(at_last_mf)
  );

  ilas_slot_check #(.MF_LEN(MF_LEN), .POS_W(POS_W), .MFI_W(MFI_W), .IDX_W(IDX_W)) u_slot (
    .pos(pos), .mf_idx(mf_idx), .octet(rx_octet), .is_ctrl(rx_is_ctrl),
    .kind(kind), .slot_ok(slot_ok), .cfg_slot(cfg_slot), .cfg_idx(cfg_idx)
  );

  ilas_cfg_store #(.FRAME_OCTETS(FRAME_OCTETS), .MF_FRAMES(MF_FRAMES), .LANE_COUNT(LANE_COUNT),
                   .CONV_COUNT(CONV_COUNT), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .clear(start_seen), .wr_en(cfg_write), .wr_idx(cfg_idx),
    .wr_data(rx_octet), .cfg_flat(cfg_octets), .valid(cfg_valid), .mismatch(cfg_mismatch),
    .lane_id(cfg_lane_id), .scramble(cfg_scramble)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SEARCH;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= violation;
      unique case (state)
        ST_SEARCH: if (start_seen) state <= ST_RUN;
        ST_RUN: begin
          if (violation) state <= ST_SEARCH;
          else if (seq_complete) begin
            state  <= ST_DONE;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ilas_done  = done_q;
  assign ilas_error = err_q;
endmodule

// File: rtl/lane_ilas_checker_sva.sv
module lane_ilas_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rx_octet,
  input logic       rx_is_ctrl,
  input logic       ilas_done,
  input logic       ilas_error,
  input logic       cfg_valid,
  input logic       cfg_mismatch,
  input logic       violation,
  input logic       start_seen
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ilas_done && !ilas_error && !cfg_valid && !cfg_mismatch));

  a_r3_start_quiet: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> (!ilas_error && !ilas_done));

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
    ilas_done |=> ilas_done);

  a_r4_done_after_end: assert property (@(posedge clk) disable iff (rst)
    $rose(ilas_done) |-> ($past(rx_is_ctrl) && $past(rx_octet) == 8'h7C));

  a_r5_violation_flags: assert property (@(posedge clk) disable iff (rst)
    violation |=> ilas_error);

  a_r5_error_pulse: assert property (@(posedge clk) disable iff (rst)
    ilas_error |=> !ilas_error);

  a_r5_no_error_when_done: assert property (@(posedge clk) disable iff (rst)
    ilas_done |-> !ilas_error);

  a_r8_valid_from_data: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> !$past(rx_is_ctrl));

  a_r10_mismatch_needs_valid: assert property (@(posedge clk) disable iff (rst)
    cfg_mismatch |-> cfg_valid);

  a_r11_start_clears_valid: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> !cfg_valid);
endmodule

bind lane_ilas_checker lane_ilas_checker_sva u_sva (
  .clk(clk), .rst(rst), .rx_octet(rx_octet), .rx_is_ctrl(rx_is_ctrl),
  .ilas_done(ilas_done), .ilas_error(ilas_error), .cfg_valid(cfg_valid),
  .cfg_mismatch(cfg_mismatch), .violation(violation), .start_seen(start_seen)
);

// File: tb/lane_ilas_checker_tb.sv
module lane_ilas_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FO = 6, KF = 3, LC = 2, MC = 2;
  localparam int MFL = KF * FO;

  typedef struct packed {
    logic [2:0] fmf;    // 7 = no fault
    logic [4:0] fpos;
    logic [7:0] foct;
    logic       fctl;
    logic [4:0] lm1;
    logic       exp_mm;
  } scen_t;

  localparam int NSCEN = 8;
  localparam scen_t SCEN [NSCEN] = '{
    '{3'd7, 5'd0,  8'h00, 1'b0, 5'd1, 1'b0},  // clean, matching
    '{3'd7, 5'd0,  8'h00, 1'b0, 5'd3, 1'b1},  // clean, lane count differs
    '{3'd0, 5'd5,  8'h7C, 1'b1, 5'd1, 1'b0},  // early end
    '{3'd3, 5'd17, 8'h00, 1'b0, 5'd1, 1'b0},  // missing end
    '{3'd1, 5'd0,  8'hBC, 1'b1, 5'd1, 1'b0},  // bad start
    '{3'd1, 5'd1,  8'h55, 1'b0, 5'd1, 1'b0},  // missing record delimiter
    '{3'd2, 5'd8,  8'hBC, 1'b1, 5'd1, 1'b0},  // control in data
    '{3'd1, 5'd5,  8'h9C, 1'b1, 5'd1, 1'b0}   // control inside record
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic [7:0]  rx_octet = 8'hBC;
  logic        rx_is_ctrl = 1'b1;
  logic        ilas_done, ilas_error, cfg_valid, cfg_mismatch, cfg_scramble;
  logic [79:0] cfg_octets;
  logic [4:0]  cfg_lane_id;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_ilas_checker #(.FRAME_OCTETS(FO), .MF_FRAMES(KF), .LANE_COUNT(LC), .CONV_COUNT(MC)) u_dut (
    .clk(clk), .rst(rst), .rx_octet(rx_octet), .rx_is_ctrl(rx_is_ctrl),
    .ilas_done(ilas_done), .ilas_error(ilas_error), .cfg_valid(cfg_valid),
    .cfg_mismatch(cfg_mismatch), .cfg_octets(cfg_octets), .cfg_lane_id(cfg_lane_id),
    .cfg_scramble(cfg_scramble)
  );

  task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_byte(int i, logic [4:0] lm1);
    case (i)
      0: return 8'hA5;
      1: return 8'h37;
      2: return 8'h0B;                  // lane id 11
      3: return {1'b1, 2'b00, lm1};     // scrambling on
      4: return 8'(FO - 1);
      5: return 8'(KF - 1);
      6: return 8'(MC - 1);
      7: return 8'h8F;
      8: return 8'h2F;
      default: return 8'h20;
    endcase
  endfunction

  function automatic logic [79:0] exp_flat(logic [4:0] lm1);
    logic [79:0] f;
    for (int i = 0; i < 10; i++) f[8*i +: 8] = cfg_byte(i, lm1);
    return f;
  endfunction

  function automatic logic [8:0] gen(int mf, int pos, logic [4:0] lm1);
    if (pos == 0)       return {1'b1, 8'h1C};
    if (pos == MFL - 1) return {1'b1, 8'h7C};
    if (mf == 1 && pos == 1) return {1'b1, 8'h9C};
    if (mf == 1 && pos >= 2 && pos < 12) return {1'b0, cfg_byte(pos - 2, lm1)};
    return {1'b0, 8'(mf * 32 + pos)};
  endfunction

  function automatic string req_of(scen_t s);
    if (int'(s.fpos) == MFL - 1 || s.foct == 8'h7C) return "R5";
    if (s.fpos == 5'd0) return "R6";
    return "R7";
  endfunction

  task automatic step(logic [7:0] o, logic c);
    @(negedge clk);
    rx_octet = o; rx_is_ctrl = c;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_octet = 8'hBC; rx_is_ctrl = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_scen(scen_t s, bit with_reset);
    logic [8:0] v;
    if (with_reset) do_reset();
    repeat (3) step(8'hBC, 1'b1);
    for (int mf = 0; mf < 4; mf++) begin
      for (int pos = 0; pos < MFL; pos++) begin
        v = gen(mf, pos, s.lm1);
        if (int'(s.fmf) == mf && int'(s.fpos) == pos) begin
          step(s.foct, s.fctl);
          chk(req_of(s), "error pulse on fault", 80'(ilas_error), 80'(1));
          chk("R4", "no done after fault", 80'(ilas_done), 80'(0));
          step(8'hBC, 1'b1);
          chk("R5", "error lasts one cycle", 80'(ilas_error), 80'(0));
          return;
        end
        step(v[7:0], v[8]);
        chk("R3", "no error on legal octet", 80'(ilas_error), 80'(0));
        if (mf == 1 && pos == 10) chk("R8", "valid not yet", 80'(cfg_valid), 80'(0));
        if (mf == 1 && pos == 11) begin
          chk("R8", "valid after last record octet", 80'(cfg_valid), 80'(1));
          chk("R8", "record octets", cfg_octets, exp_flat(s.lm1));
        end
        if (mf == 3 && pos == MFL - 1) begin
          chk("R4", "done after fourth end", 80'(ilas_done), 80'(1));
          chk("R10", "mismatch", 80'(cfg_mismatch), 80'(s.exp_mm));
          chk("R9", "lane id", 80'(cfg_lane_id), 80'(11));
          chk("R9", "scramble flag", 80'(cfg_scramble), 80'(1));
        end else begin
          chk("R3", "done not early", 80'(ilas_done), 80'(0));
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    finish_run();
  end

  initial begin
    // R1: initial reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "done after reset", 80'(ilas_done), 80'(0));
    chk("R1", "error after reset", 80'(ilas_error), 80'(0));
    chk("R1", "valid after reset", 80'(cfg_valid), 80'(0));
    chk("R1", "mismatch after reset", 80'(cfg_mismatch), 80'(0));
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NSCEN; i++) run_scen(SCEN[i], 1'b1);

    // R2: stray characters ignored while searching, then a clean run still completes
    do_reset();
    step(8'h1C, 1'b0); chk("R2", "data 0x1C ignored", 80'(ilas_error), 80'(0));
    step(8'h7C, 1'b1); chk("R2", "end char ignored", 80'(ilas_error), 80'(0));
    step(8'h9C, 1'b1); chk("R2", "delimiter ignored", 80'(ilas_error), 80'(0));
    step(8'h00, 1'b0); chk("R2", "still idle", 80'(cfg_valid | ilas_done), 80'(0));
    run_scen(SCEN[0], 1'b0);

    // R4: after completion everything is ignored
    step(8'h7C, 1'b1);
    step(8'h1C, 1'b1);
    step(8'h55, 1'b1);
    chk("R4", "done holds", 80'(ilas_done), 80'(1));
    chk("R4", "no error after done", 80'(ilas_error), 80'(0));
    chk("R4", "record unchanged", cfg_octets, exp_flat(5'd1));

    // R11: record survives an error, next start clears valid
    run_scen(SCEN[6], 1'b1);
    chk("R11", "valid kept after error", 80'(cfg_valid), 80'(1));
    step(8'h1C, 1'b1);
    chk("R11", "valid cleared by start", 80'(cfg_valid), 80'(0));

    // R1: reset in the middle of a sequence
    step(8'h00, 1'b0);
    do_reset();
    chk("R1", "mid-run reset clears done", 80'(ilas_done), 80'(0));
    step(8'h7C, 1'b1);
    chk("R1", "back in search after reset", 80'(ilas_error), 80'(0));

    finish_run();
  end
endmodule